// File: doc/BRIEF.md
# Store Address and Byte-Mask Generator

This block forms the virtual address of a scalar store from a base register and a signed 12-bit offset. It produces the byte-enable mask for the access width and a flag that marks a misaligned address. It is purely combinational and sits in the address stage of a store pipeline. Every output is valid in the same cycle as the operands that produce it.

A full-width adder would be slow here, so the sum is split. A 12-bit adder forms the low part and its carry. At the same time the upper part of the base is prepared in three forms: unchanged, incremented and decremented. The low-part carry and the offset's sign bit pick one of the three, so the long carry chain never reaches the upper bits. A parameter can replace the select with a plain adder.

The byte mask is 16 bits wide. It holds 1, 2, 4 or 8 consecutive ones, placed at the address's offset within a 16-byte window.

Top module: `store_addr_gen`

## Requirements
- R1: The low 12 address bits equal (base[11:0] + imm[11:0]) modulo 4096. The 12-bit offset is zero-extended for this sum, and bit 12 of the 13-bit sum is the low carry.
- R2: When the low carry is 1 and the offset sign bit imm[11] is 1, the upper address bits equal the base's upper bits unchanged.
- R3: When the low carry is 1 and imm[11] is 0, the upper address bits equal the base's upper bits plus one, wrapping at the top.
- R4: When the low carry is 0 and imm[11] is 1, the upper address bits equal the base's upper bits minus one, wrapping below zero.
- R5: When the low carry is 0 and imm[11] is 0, the upper address bits equal the base's upper bits unchanged.
- R6: The full address equals base plus the sign-extended offset, modulo 2^ADDR_W (ADDR_W defaults to 39).
- R7: Size code 2'b01 (halfword) is misaligned when addr[0] is 1. Code 2'b10 (word) is misaligned when addr[1:0] is nonzero. Code 2'b11 (doubleword) is misaligned when addr[2:0] is nonzero.
- R8: Size code 2'b00 (byte) never raises the misalignment flag.
- R9: Bit i of the 16-bit byte mask is 1 exactly when addr[3:0] <= i < addr[3:0] + N, where N is 1, 2, 4 or 8 for size codes 00, 01, 10 and 11. Mask bits that would land above bit 15 are dropped.
- R10: All outputs follow the inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | ADDR_W | Base register value |
| imm_i | input | 12 | Signed address offset |
| size_i | input | 2 | Access size code (00 byte, 01 half, 10 word, 11 double) |
| vaddr_o | output | ADDR_W | Computed virtual address |
| bmask_o | output | 16 | Byte-enable mask within a 16-byte window |
| misalign_o | output | 1 | Address is not aligned to the access size |

## Verification
Two functions can act on the same operand in one cycle. The upper part can take an increment or decrement while the misalignment check and the mask placement look at low bits that have just wrapped through the 12-bit boundary. The sweep provokes this by pairing base low parts near 0x000 and 0xFFF with offsets near 0x000, 0x7FF, 0x800 and 0xFFF, across all four size codes. The address is judged against a full-width reference sum, and the flag and the mask are judged against values the bench computes from the final address bits.

// File: rtl/sag_pkg.sv
package sag_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_DBL  = 2'b11
   } sag_size_e;

   // number of bytes touched by a given size code
   function automatic int unsigned sag_nbytes(input logic [1:0] sz);
      return 32'd1 << sz;
   endfunction

endpackage

// File: rtl/sag_low_add.sv
module sag_low_add #(
   parameter int LOW_W = 12
) (
   input  logic [LOW_W-1:0] base_lo_i,
   input  logic [LOW_W-1:0] imm_i,
   output logic [LOW_W-1:0] sum_o,
   output logic             carry_o
);
   logic [LOW_W:0] wide_sum;

   always_comb begin
      wide_sum = {1'b0, base_lo_i} + {1'b0, imm_i};
      sum_o    = wide_sum[LOW_W-1:0];
      carry_o  = wide_sum[LOW_W];
   end
endmodule

// File: rtl/sag_high_sel.sv
module sag_high_sel #(
   parameter int HI_W         = 27,
   parameter bit CARRY_SELECT = 1'b1
) (
   input  logic [HI_W-1:0] base_hi_i,
   input  logic            carry_i,
   input  logic            sign_i,
   output logic [HI_W-1:0] hi_o
);
   if (CARRY_SELECT) begin : g_select
      logic [HI_W-1:0] cand_keep;
      logic [HI_W-1:0] cand_inc;
      logic [HI_W-1:0] cand_dec;

      always_comb begin
         cand_keep = base_hi_i;
         cand_inc  = base_hi_i + {{(HI_W-1){1'b0}}, 1'b1};
         cand_dec  = base_hi_i + {HI_W{1'b1}};
         unique case ({carry_i, sign_i})
            2'b10:   hi_o = cand_inc;
            2'b01:   hi_o = cand_dec;
            default: hi_o = cand_keep;
         endcase
      end
   end else begin : g_adder
      always_comb begin
         hi_o = base_hi_i + {HI_W{sign_i}} + {{(HI_W-1){1'b0}}, carry_i};
      end
   end

   always_comb begin
      if (!$isunknown({base_hi_i, carry_i, sign_i, hi_o})) begin
         // R2 R4 R5
         hi_step_chk: assert ((hi_o == base_hi_i)
                              || (hi_o == base_hi_i + 1'b1)
                              || (hi_o == base_hi_i - 1'b1))
            else $error("upper part moved by more than one");
         // R3
         hi_inc_chk: assert (!(carry_i && !sign_i) || (hi_o != base_hi_i))
            else $error("upper part not incremented on carry");
      end
   end
endmodule

// File: rtl/sag_align_chk.sv
module sag_align_chk
   import sag_pkg::*;
(
   input  logic [2:0] addr_lo_i,
   input  logic [1:0] size_i,
   output logic       misalign_o
);
   always_comb begin
      unique case (sag_size_e'(size_i))
         SZ_BYTE: misalign_o = 1'b0;
         SZ_HALF: misalign_o = addr_lo_i[0];
         SZ_WORD: misalign_o = |addr_lo_i[1:0];
         SZ_DBL:  misalign_o = |addr_lo_i;
         default: misalign_o = 1'b0;
      endcase
   end

   always_comb begin
      if (!$isunknown({size_i, misalign_o})) begin
         // R8
         byte_align_chk: assert (!(size_i == 2'b00 && misalign_o))
            else $error("byte access flagged misaligned");
      end
   end
endmodule

// File: rtl/sag_mask_gen.sv
module sag_mask_gen #(
   parameter int MASK_BYTES = 16,
   localparam int OFF_W     = $clog2(MASK_BYTES)
) (
   input  logic [OFF_W-1:0]      offset_i,
   input  logic [1:0]            size_i,
   output logic [MASK_BYTES-1:0] mask_o
);
   import sag_pkg::*;

   logic [OFF_W+1:0] span_end;

   always_comb begin
      span_end = {2'b00, offset_i} + (OFF_W+2)'(sag_nbytes(size_i));
   end

   for (genvar b = 0; b < MASK_BYTES; b++) begin : g_lane
      localparam logic [OFF_W+1:0] LANE = (OFF_W+2)'(b);
      always_comb begin
         mask_o[b] = (LANE >= {2'b00, offset_i}) && (LANE < span_end);
      end
   end

   always_comb begin
      if (!$isunknown({offset_i, size_i, mask_o})) begin
         // R9
         mask_pop_chk: assert (($countones(mask_o) == sag_nbytes(size_i))
                               || (span_end > (OFF_W+2)'(MASK_BYTES)))
            else $error("mask population wrong for in-window access");
         // R9
         mask_base_chk: assert (mask_o[offset_i])
            else $error("mask lane at offset not set");
      end
   end
endmodule

// File: rtl/store_addr_gen.sv
module store_addr_gen #(
   parameter int ADDR_W       = 39,
   parameter int MASK_BYTES   = 16,
   parameter bit CARRY_SELECT = 1'b1
) (
   input  logic [ADDR_W-1:0]     base_i,
   input  logic [11:0]           imm_i,
   input  logic [1:0]            size_i,
   output logic [ADDR_W-1:0]     vaddr_o,
   output logic [MASK_BYTES-1:0] bmask_o,
   output logic                  misalign_o
);
   localparam int IMM_W = 12;
   localparam int HI_W  = ADDR_W - IMM_W;
   localparam int OFF_W = $clog2(MASK_BYTES);

   if (ADDR_W <= IMM_W) begin : g_bad_width
      $error("ADDR_W must exceed the offset width");
   end
   if (MASK_BYTES < 8 || (MASK_BYTES & (MASK_BYTES - 1)) != 0) begin : g_bad_mask
      $error("MASK_BYTES must be a power of two of at least 8");
   end

   logic [IMM_W-1:0] low_sum;
   logic             low_carry;
   logic [HI_W-1:0]  hi_part;

   sag_low_add #(.LOW_W(IMM_W)) u_low (
      .base_lo_i (base_i[IMM_W-1:0]),
      .imm_i     (imm_i),
      .sum_o     (low_sum),
      .carry_o   (low_carry)
   );

   sag_high_sel #(.HI_W(HI_W), .CARRY_SELECT(CARRY_SELECT)) u_high (
      .base_hi_i (base_i[ADDR_W-1:IMM_W]),
      .carry_i   (low_carry),
      .sign_i    (imm_i[IMM_W-1]),
      .hi_o      (hi_part)
   );

   always_comb begin
      vaddr_o = {hi_part, low_sum};
   end

   sag_align_chk u_align (
      .addr_lo_i  (vaddr_o[2:0]),
      .size_i     (size_i),
      .misalign_o (misalign_o)
   );

   sag_mask_gen #(.MASK_BYTES(MASK_BYTES)) u_mask (
      .offset_i (vaddr_o[OFF_W-1:0]),
      .size_i   (size_i),
      .mask_o   (bmask_o)
   );

   logic [ADDR_W-1:0] ref_sum;
   always_comb begin
      ref_sum = base_i + {{HI_W{imm_i[IMM_W-1]}}, imm_i};
      if (!$isunknown({base_i, imm_i, size_i, vaddr_o, misalign_o})) begin
         // R6
         addr_sum_chk: assert (vaddr_o == ref_sum)
            else $error("address differs from full-width sum");
         // R7
         misalign_size_chk: assert (!misalign_o || (size_i != 2'b00 && vaddr_o[0] | vaddr_o[1] | vaddr_o[2]))
            else $error("misalignment raised on aligned address");
      end
   end
endmodule

// File: tb/sim_store_addr_gen.sv
`timescale 1ns/1ps
module sim_store_addr_gen;
   localparam int AW = 39;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] base;
   logic [11:0]   imm;
   logic [1:0]    size;
   logic [AW-1:0] vaddr;
   logic [15:0]   bmask;
   logic          misal;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   store_addr_gen #(.ADDR_W(AW), .MASK_BYTES(16), .CARRY_SELECT(1'b1)) u0 (
      .base_i     (base),
      .imm_i      (imm),
      .size_i     (size),
      .vaddr_o    (vaddr),
      .bmask_o    (bmask),
      .misalign_o (misal)
   );

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic judge();
      logic [12:0]   lsum;
      logic          cy;
      logic          sg;
      logic [AW-1:0] exp_a;
      logic [AW-13:0] exp_hi;
      logic          exp_m;
      logic [31:0]   exp_k;
      string         rq;
      lsum  = {1'b0, base[11:0]} + {1'b0, imm};
      cy    = lsum[12];
      sg    = imm[11];
      exp_a = base + {{(AW-12){imm[11]}}, imm};
      // R1
      check(vaddr[11:0] == lsum[11:0], "R1", 64'(vaddr[11:0]), 64'(lsum[11:0]));
      // upper part, per carry/sign case
      exp_hi = base[AW-1:12];
      if (cy && sg)       begin rq = "R2"; end
      else if (cy && !sg) begin rq = "R3"; exp_hi = exp_hi + 1'b1; end
      else if (!cy && sg) begin rq = "R4"; exp_hi = exp_hi - 1'b1; end
      else                begin rq = "R5"; end
      check(vaddr[AW-1:12] == exp_hi, rq, 64'(vaddr[AW-1:12]), 64'(exp_hi));
      // R6
      check(vaddr == exp_a, "R6", 64'(vaddr), 64'(exp_a));
      case (size)
         2'b00: exp_m = 1'b0;
         2'b01: exp_m = exp_a[0];
         2'b10: exp_m = |exp_a[1:0];
         default: exp_m = |exp_a[2:0];
      endcase
      check(misal == exp_m, (size == 2'b00) ? "R8" : "R7", 64'(misal), 64'(exp_m));
      exp_k = ((32'd1 << (32'd1 << size)) - 32'd1) << exp_a[3:0];
      // R9
      check(bmask == exp_k[15:0], "R9", 64'(bmask), 64'(exp_k[15:0]));
   endtask

   task automatic apply(input logic [AW-1:0] b, input logic [11:0] i, input logic [1:0] s);
      @(negedge clk);
      base = b; imm = i; size = s;
      @(posedge clk);
      #1;
      judge();
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] his [4];
      logic [11:0]   imms [10];
      base = '0; imm = '0; size = 2'b00;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #1;
      // idle state with zero operands: R6 R9 R8
      check(vaddr == '0, "R6", 64'(vaddr), 64'd0);
      check(bmask == 16'h0001, "R9", 64'(bmask), 64'h1);
      check(misal == 1'b0, "R8", 64'(misal), 64'd0);

      his[0] = '0;
      his[1] = {{(AW-13){1'b0}}, 1'b1, 12'h000};
      his[2] = {AW{1'b1}} & ~{{(AW-12){1'b0}}, 12'hFFF};
      his[3] = {3'b101, 24'h5A5A5A, 12'h000};
      imms[0] = 12'h000; imms[1] = 12'h001; imms[2] = 12'h7FF;
      imms[3] = 12'h800; imms[4] = 12'hFFF; imms[5] = 12'hFF8;
      imms[6] = 12'h008; imms[7] = 12'h123; imms[8] = 12'hA5C;
      imms[9] = 12'h3FE;

      // carry/borrow boundaries crossed with every size
      for (int h = 0; h < 4; h++)
         for (int lo = 0; lo < 4096; lo += 37)
            for (int k = 0; k < 10; k++)
               for (int s = 0; s < 4; s++)
                  apply(his[h] | AW'(lo), imms[k], 2'(s));
      for (int h = 0; h < 4; h++)
         for (int k = 0; k < 10; k++)
            for (int s = 0; s < 4; s++) begin
               apply(his[h] | AW'(12'hFFF), imms[k], 2'(s));
               apply(his[h] | AW'(12'h000), imms[k], 2'(s));
            end

      // random operands
      for (int r = 0; r < 3000; r++)
         apply({$urandom(), $urandom()} & {AW{1'b1}}, 12'($urandom()), 2'($urandom()));

      // R10: outputs settle with no clock edge in between
      @(negedge clk);
      base = AW'(39'h12_3456_7FF8); imm = 12'h00A; size = 2'b11;
      #0.5;
      check(vaddr == AW'(39'h12_3456_8002), "R10", 64'(vaddr), 64'h12_3456_8002);
      check(misal == 1'b1, "R10", 64'(misal), 64'd1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule